// File: doc/BRIEF.md
# Tuning Register Bus Target

This block connects a serial two-wire bus (I2C, standard and fast mode) to a small register file inside a temperature-compensated oscillator controller. A system clock oversamples both bus lines and filters them. The block recognises START and STOP conditions, matches a fixed 7-bit device address, and keeps a two-bit register pointer that advances after every byte. It acknowledges bytes and returns read data by pulling the data line low; it never drives the line high.

There are four byte registers. Two are writable and together form a signed frequency-trim word and a flag that freezes compensation. The other two are read-only and show a copy of the on-chip temperature. That copy is refreshed only when a write header or a word address arrives. A master that reads both temperature bytes in one burst therefore always gets two halves of the same sample.

The trim word and the freeze flag are outputs that come straight from registers. A one-cycle strobe tells the compensation logic that the low trim byte has just been written.

Top module: `tune_i2c_target`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits are 1000001, which is 82h for a write and 83h for a read. After any other address byte it acknowledges nothing and ignores the bus until the next START or STOP.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START in the middle of a transfer begins a new address phase.
- R3: In a write transfer, the first byte after the address loads the register pointer from its two low bits. Each later byte is stored at the pointer, and the pointer then advances. Every byte of an addressed write is acknowledged.
- R4: A read returns bytes starting at the current pointer, which is the value the last transfer left behind if no word address was sent first. The pointer advances after each byte. The pointer wraps from 03h to 00h for both reads and writes.
- R5: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START or STOP.
- R6: Register 00h bit 7 is output `comp_hold`, and its bits 6..0 are `tune_word[14:8]`. Register 01h is `tune_word[7:0]`. `tune_word` is 15-bit two's complement with bit 14 as the sign. Both registers reset to 00h.
- R7: Register 02h reads snapshot bits 11..4. Register 03h reads snapshot bits 3..0 in its upper nibble and 0000 in its lower nibble. After reset the snapshot is 190h, which is +25 °C at 1/16 °C per code.
- R8: The snapshot copies `live_temp` when an accepted write address byte completes and when a word address byte completes. Reads never update it.
- R9: Bytes written to 02h or 03h are acknowledged and discarded. They change neither the snapshot nor any output.
- R10: `tune_updated` pulses high for exactly one cycle for each byte written to 01h, and at no other time.
- R11: A pulse shorter than FILT_CYC system clocks on SCL or SDA has no effect on the protocol.
- R12: The block starts pulling SDA low only while SCL is low, after a falling edge of SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| live_temp | input | 12 | Current temperature code from the sensor path |
| sda_pull | output | 1 | High pulls the data line low (open drain) |
| tune_word | output | 15 | Signed frequency-trim value |
| comp_hold | output | 1 | Freeze temperature compensation |
| tune_updated | output | 1 | One-cycle strobe after a write to register 01h |

## Verification
The hardest conditions to reach from the ports are sub-threshold pulses that land inside a live byte. One is an SDA spike while SCL is high, which would otherwise be seen as a false START or STOP. The other is a spike on SCL while it is low, which would otherwise add a phantom bit. The bench sends a trim byte in which every bit carries both kinds of spike, and then confirms that the byte lands intact. The snapshot coherence case is reached by changing `live_temp` between transfers. The bench then reads the temperature back with and without a new word address, behind a repeated START, and checks which sample comes back.

// File: rtl/tune_i2c_pkg.sv
package tune_i2c_pkg;
  localparam int BYTE_W  = 8;
  localparam int PTR_W   = 2;
  localparam int TEMP_W  = 12;
  localparam int TUNE_W  = 15;
  localparam int NUM_REG = 1 << PTR_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACKW, ST_ACK, ST_TX, ST_TXEND, ST_MACK, ST_IGNORE
  } link_state_t;

  typedef enum logic [1:0] {K_ADDR, K_WORD, K_DATA} rx_kind_t;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int FILT_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      dout <= 1'b1;
      cnt  <= '0;
    end else begin
      s1 <= din;
      s2 <= s1;
      if (s2 == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_CYC - 1)) begin
        dout <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_events.sv
module bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  // conditions are judged only while SCL stays high across both samples
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/link_fsm.sv
module link_fsm
  import tune_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_f,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PTR_W-1:0]  ptr,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              snap_en,
  output logic              pull
);
  link_state_t       state;
  rx_kind_t          kind;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-2:0] tx;
  logic              rd_mode;
  logic              ack_seen;

  always_ff @(posedge clk) begin
    wr_en   <= 1'b0;
    snap_en <= 1'b0;
    if (rst) begin
      state    <= ST_IDLE;
      kind     <= K_ADDR;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx       <= '0;
      rd_mode  <= 1'b0;
      ack_seen <= 1'b0;
      ptr      <= '0;
      wr_ptr   <= '0;
      wr_data  <= '0;
      pull     <= 1'b0;
    end else if (start_evt) begin
      state   <= ST_RX;
      kind    <= K_ADDR;
      bit_cnt <= '0;
      pull    <= 1'b0;
    end else if (stop_evt) begin
      state <= ST_IDLE;
      pull  <= 1'b0;
    end else begin
      case (state)
        ST_RX: if (scl_rise) begin
          shreg   <= {shreg[BYTE_W-3:0], sda_f};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == 3'd7) begin
            case (kind)
              K_ADDR: begin
                if (shreg == DEV_ADDR) begin
                  rd_mode <= sda_f;
                  snap_en <= ~sda_f;
                  state   <= ST_ACKW;
                end else begin
                  state <= ST_IGNORE;
                end
              end
              K_WORD: begin
                ptr     <= {shreg[PTR_W-2:0], sda_f};
                snap_en <= 1'b1;
                state   <= ST_ACKW;
              end
              default: begin
                wr_en   <= 1'b1;
                wr_data <= {shreg, sda_f};
                wr_ptr  <= ptr;
                ptr     <= ptr + 1'b1;
                state   <= ST_ACKW;
              end
            endcase
          end
        end
        ST_ACKW: if (scl_fall) begin
          pull     <= 1'b1;
          ack_seen <= 1'b0;
          state    <= ST_ACK;
        end
        ST_ACK: begin
          if (scl_rise) begin
            ack_seen <= 1'b1;
          end else if (scl_fall && ack_seen) begin
            bit_cnt <= '0;
            if (kind == K_ADDR && rd_mode) begin
              tx    <= rd_data[BYTE_W-2:0];
              pull  <= ~rd_data[BYTE_W-1];
              ptr   <= ptr + 1'b1;
              state <= ST_TX;
            end else begin
              pull  <= 1'b0;
              kind  <= (kind == K_ADDR) ? K_WORD : K_DATA;
              state <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 3'd7) state <= ST_TXEND;
          end else if (scl_fall) begin
            pull <= ~tx[BYTE_W-2];
            tx   <= {tx[BYTE_W-3:0], 1'b0};
          end
        end
        ST_TXEND: if (scl_fall) begin
          pull     <= 1'b0;
          ack_seen <= 1'b0;
          state    <= ST_MACK;
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (sda_f) state <= ST_IGNORE;
            else       ack_seen <= 1'b1;
          end else if (scl_fall && ack_seen) begin
            tx      <= rd_data[BYTE_W-2:0];
            pull    <= ~rd_data[BYTE_W-1];
            ptr     <= ptr + 1'b1;
            bit_cnt <= '0;
            state   <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tune_regs.sv
module tune_regs
  import tune_i2c_pkg::*;
#(
  parameter logic [TEMP_W-1:0] TEMP_RESET = 12'h190
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              snap_en,
  input  logic [TEMP_W-1:0] live_temp,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [TUNE_W-1:0] tune_word,
  output logic              comp_hold,
  output logic              tune_updated
);
  localparam int LOW_NIB = 2 * BYTE_W - TEMP_W;

  logic [BYTE_W-1:0] ctl_q, low_q;
  logic [TEMP_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q        <= '0;
      low_q        <= '0;
      snap_q       <= TEMP_RESET;
      tune_updated <= 1'b0;
    end else begin
      tune_updated <= 1'b0;
      if (snap_en) snap_q <= live_temp;
      if (wr_en) begin
        case (wr_ptr)
          PTR_W'(0): ctl_q <= wr_data;
          PTR_W'(1): begin
            low_q        <= wr_data;
            tune_updated <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_ptr)
      PTR_W'(0): rd_data = ctl_q;
      PTR_W'(1): rd_data = low_q;
      PTR_W'(2): rd_data = snap_q[TEMP_W-1 -: BYTE_W];
      default:   rd_data = {snap_q[TEMP_W-BYTE_W-1:0], {LOW_NIB{1'b0}}};
    endcase
  end

  assign tune_word = {ctl_q[BYTE_W-2:0], low_q};
  assign comp_hold = ctl_q[BYTE_W-1];
endmodule

// File: rtl/tune_i2c_target.sv
module tune_i2c_target
  import tune_i2c_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR   = 7'b1000001,
  parameter int                FILT_CYC   = 13,
  parameter logic [TEMP_W-1:0] TEMP_RESET = 12'h190
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [TEMP_W-1:0] live_temp,
  output logic              sda_pull,
  output logic [TUNE_W-1:0] tune_word,
  output logic              comp_hold,
  output logic              tune_updated
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, filt_lines;
  logic scl_filt, sda_filt;
  logic scl_rise, scl_fall, start_evt, stop_evt;
  logic [PTR_W-1:0]  ptr, wr_ptr;
  logic              wr_en, snap_en;
  logic [BYTE_W-1:0] wr_data, rd_data;

  assign raw_lines = {scl_in, sda_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .dout(filt_lines[g])
    );
  end

  assign scl_filt = filt_lines[1];
  assign sda_filt = filt_lines[0];

  bus_events u_evt (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (scl_filt),
    .sda_f    (sda_filt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  link_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_f    (sda_filt),
    .rd_data  (rd_data),
    .ptr      (ptr),
    .wr_ptr   (wr_ptr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .snap_en  (snap_en),
    .pull     (sda_pull)
  );

  tune_regs #(.TEMP_RESET(TEMP_RESET)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_ptr      (wr_ptr),
    .wr_data     (wr_data),
    .snap_en     (snap_en),
    .live_temp   (live_temp),
    .rd_ptr      (ptr),
    .rd_data     (rd_data),
    .tune_word   (tune_word),
    .comp_hold   (comp_hold),
    .tune_updated(tune_updated)
  );
endmodule

// File: rtl/tune_i2c_checks.sv
module tune_i2c_checks (
  input logic        clk,
  input logic        rst,
  input logic        sda_pull,
  input logic        tune_updated,
  input logic [14:0] tune_word,
  input logic        scl_f,
  input logic        stop_evt
);
  logic armed;
  always_ff @(posedge clk) armed <= ~rst;

  // R12: the pull only begins while the filtered clock is low
  a_r12_pull_starts_low: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(sda_pull)) |-> !scl_f);

  // R10: the strobe never lasts more than one cycle
  a_r10_strobe_single: assert property (@(posedge clk) disable iff (rst)
    (armed && tune_updated) |=> !tune_updated);

  // R10: the low trim byte changes only together with the strobe
  a_r10_low_change_strobed: assert property (@(posedge clk) disable iff (rst)
    (armed && $changed(tune_word[7:0])) |-> tune_updated);

  // R5: after a STOP the data line is released
  a_r5_release_after_stop: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(stop_evt)) |-> !sda_pull);
endmodule

bind tune_i2c_target tune_i2c_checks u_checks (
  .clk         (clk),
  .rst         (rst),
  .sda_pull    (sda_pull),
  .tune_updated(tune_updated),
  .tune_word   (tune_word),
  .scl_f       (scl_filt),
  .stop_evt    (stop_evt)
);

// File: tb/sim_tune_i2c_target.sv
module sim_tune_i2c_target;
  localparam int Q = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [11:0] live_temp = 12'h3A5;
  logic        sda_pull, comp_hold, tune_updated;
  logic [14:0] tune_word;
  logic        sda_bus;
  assign sda_bus = sda_m & ~sda_pull;

  tune_i2c_target u0 (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus),
    .live_temp(live_temp), .sda_pull(sda_pull), .tune_word(tune_word),
    .comp_hold(comp_hold), .tune_updated(tune_updated)
  );

  // reference model
  logic [7:0]  m_reg0 = 8'h00, m_reg1 = 8'h00;
  logic [11:0] m_snap = 12'h190;
  int          m_ptr = 0;
  int          m_pulses = 0;
  int          seen_pulses = 0;
  bit          quiet = 1'b0;
  int          mism = 0;
  int          r12_viol = 0;
  logic        scl_prev = 1'b1, pull_prev = 1'b0;
  int          checks = 0, fails = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  function automatic logic [7:0] m_byte(int p);
    case (p)
      0: return m_reg0;
      1: return m_reg1;
      2: return m_snap[11:4];
      default: return {m_snap[3:0], 4'h0};
    endcase
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (tune_updated) seen_pulses++;
      if (quiet && (tune_word !== {m_reg0[6:0], m_reg1} || comp_hold !== m_reg0[7])) mism++;
      if (scl_m && scl_prev && sda_pull !== pull_prev) r12_viol++;
    end
    scl_prev  = scl_m;
    pull_prev = sda_pull;
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wq(int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b0; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(1); sda_m = 1'b1; wq(2);
  endtask

  task automatic put_bit(logic b);
    sda_m = b; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
  endtask

  task automatic put_bit_glitch(logic b);
    sda_m = b; wq(1); scl_m = 1'b1; wq(1);
    sda_m = ~b; repeat (6) @(negedge clk); sda_m = b;
    repeat (Q - 6) @(negedge clk); scl_m = 1'b0;
    repeat (Q / 2) @(negedge clk);
    scl_m = 1'b1; repeat (6) @(negedge clk); scl_m = 1'b0;
    repeat (Q / 2 - 6) @(negedge clk);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1); b = sda_bus; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic send_byte(logic [7:0] d, bit glitch, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      if (glitch) put_bit_glitch(d[i]);
      else        put_bit(d[i]);
    end
    get_bit(a);
    acked = (a == 1'b0);
  endtask

  task automatic recv_byte(bit last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(last);
  endtask

  task automatic model_write(logic [7:0] d);
    if (m_ptr == 0) m_reg0 = d;
    if (m_ptr == 1) begin m_reg1 = d; m_pulses++; end
    m_ptr = (m_ptr + 1) % 4;
  endtask

  // write transfer: word address then data bytes
  task automatic wr_txn(logic [7:0] wa, logic [7:0] data[$], bit glitch, string tag);
    bit ack;
    quiet = 1'b0;
    i2c_start();
    send_byte(8'h82, 1'b0, ack);
    m_snap = live_temp;
    check({"R1 write address ack ", tag}, ack, 1);
    send_byte(wa, 1'b0, ack);
    m_ptr = wa % 4;
    m_snap = live_temp;
    check({"R3 word address ack ", tag}, ack, 1);
    foreach (data[i]) begin
      send_byte(data[i], glitch, ack);
      check({"R3 data ack ", tag}, ack, 1);
      model_write(data[i]);
    end
    i2c_stop();
    wq(1);
    quiet = 1'b1;
  endtask

  // read transfer, optionally preceded by a word address and repeated START
  task automatic rd_txn(bit set_word, logic [7:0] wa, int n, string tag);
    bit ack;
    logic [7:0] d;
    quiet = 1'b0;
    if (set_word) begin
      i2c_start();
      send_byte(8'h82, 1'b0, ack);
      m_snap = live_temp;
      send_byte(wa, 1'b0, ack);
      m_ptr = wa % 4;
      m_snap = live_temp;
      check({"R2 word before repeated start ", tag}, ack, 1);
    end
    i2c_start();
    send_byte(8'h83, 1'b0, ack);
    check({"R1 read address ack ", tag}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, d);
      check({"R4 read byte ", tag}, d, m_byte(m_ptr));
      m_ptr = (m_ptr + 1) % 4;
    end
    repeat (Q / 2) @(negedge clk);
    check({"R5 released after NACK ", tag}, sda_pull, 0);
    i2c_stop();
    wq(1);
    quiet = 1'b1;
  endtask

  initial begin
    bit ack;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    quiet = 1'b1;
    check("R6 reset tune_word", tune_word, 0);
    check("R6 reset comp_hold", comp_hold, 0);
    check("R5 reset sda_pull", sda_pull, 0);
    check("R10 reset strobe", tune_updated, 0);

    // R4 R7: reset contents with wrap, no word address
    rd_txn(1'b0, 8'h00, 5, "reset contents R7");

    // R3 R6: write control and low byte
    wr_txn(8'h00, '{8'h85, 8'h3C}, 1'b0, "trim");
    check("R6 tune_word after write", tune_word, 15'h053C);
    check("R6 comp_hold after write", comp_hold, 1);
    check("R10 one strobe per low byte", seen_pulses, m_pulses);

    // R8: live temperature moves, read shows the old snapshot
    live_temp = 12'h7FF;
    rd_txn(1'b0, 8'h00, 2, "R8 snapshot held");

    // R9 R4: writes to read-only registers and wrap to 00h
    wr_txn(8'h01, '{8'hFF, 8'hAA, 8'h55, 8'h7F}, 1'b0, "wrap R9");
    check("R6 negative trim", tune_word, 15'h7FFF);
    check("R10 strobe count after wrap", seen_pulses, m_pulses);

    // R2 R8: word address with repeated START refreshes the snapshot
    live_temp = 12'h123;
    rd_txn(1'b1, 8'h02, 2, "R8 refreshed");

    // R1: foreign address is ignored
    quiet = 1'b0;
    i2c_start();
    send_byte(8'h84, 1'b0, ack);
    check("R1 foreign address not acked", ack, 0);
    send_byte(8'h00, 1'b0, ack);
    check("R1 following byte not acked", ack, 0);
    i2c_stop();
    wq(1);
    quiet = 1'b1;

    // R11: spikes on both lines within every bit
    wr_txn(8'h01, '{8'h12}, 1'b1, "R11 glitch");
    check("R11 byte intact through spikes", tune_word, 15'h7F12);

    // R10: write of 00h only gives no strobe
    wr_txn(8'h00, '{8'h80}, 1'b0, "control only");
    check("R10 no strobe for 00h", seen_pulses, m_pulses);
    rd_txn(1'b1, 8'h00, 2, "final R6");

    check("R6 outputs track model every clock", mism, 0);
    check("R12 pull steady while SCL high", r12_viol, 0);
    done = 1'b1;
  end

  initial begin
    wait (done || cyc > 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule